// File: doc/BRIEF.md
# Piecewise-Linear Pixel Code Compander

This block maps a stream of 13-bit pixel codes into one of three output formats: a 10-bit code shaped by a programmable four-segment curve, a 12-bit code saturated at its top, or the 13-bit code unchanged. A 2-bit format field picks the format for each input word. In the companded format, three ordered knee inputs divide the input range into four segments. Each segment has an unsigned slope that holds 256 times the real slope, and a signed offset. The segment's output is the offset plus the input times the slope, divided by 256 with the remainder dropped. The result is then limited to the 10-bit range.

A black-clip control forces every companded input below the black code (64) to the first segment's offset. This removes codes darker than black. With the control off, the first segment also covers inputs below black. Software computes the knees, slopes and offsets. The block only applies them. Data moves through two register stages: segment selection, then multiply, add and format. A valid flag follows the data through both stages.

Top module: `pwl_compander`

## Requirements
- R1: When cfg_mode[1] is 0, the output is companded. The 10-bit result appears on out_code[9:0] and out_code[12:10] is zero.
- R2: When cfg_mode is 2'b10, out_code equals the input code unchanged.
- R3: When cfg_mode is 2'b11, inputs up to 4095 pass unchanged and any input above 4095 gives 4095.
- R4: Knees are programmed with knee0 <= knee1 <= knee2. Segment 0 is used for x < knee0, segment 1 for knee0 <= x < knee1, segment 2 for knee1 <= x < knee2, and segment 3 for x >= knee2.
- R5: The companded value for segment i is ofs_i + floor(x * slope_i / 256). slope_i is a 12-bit unsigned field and ofs_i is a 14-bit two's-complement field.
- R6: The companded value is saturated: a negative result gives 0 and a result above 1023 gives 1023.
- R7: With cfg_blk_clip high in companded mode, every input below 64 gives ofs_0, saturated as in R6. With cfg_blk_clip low, inputs below 64 use segment 0 as in R5.
- R8: out_vld equals in_vld from two clock edges earlier. out_code at that edge is the result for the input sampled with it.
- R9: While rst_n is low at a clock edge, out_vld and out_code are cleared to 0.
- R10: With every knee at 8191, slope 32 and offset 0, the companded output equals x / 8 truncated, for x up to 8190.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Input code is valid |
| in_code | input | 13 | Input pixel code |
| cfg_mode | input | 2 | Output format: 0x companded, 10 pass-through, 11 clipped to 12 bits |
| cfg_blk_clip | input | 1 | Force companded inputs below 64 to ofs_0 |
| cfg_knee | input | 3x13 | Knee inputs, element k is knee k |
| cfg_slope | input | 4x12 | Per-segment slope times 256, unsigned |
| cfg_ofs | input | 4x14 | Per-segment offset, two's complement |
| out_vld | output | 1 | Output code is valid |
| out_code | output | 13 | Formatted output code |

## Verification
Assertions check the following on every cycle: the two-edge valid latency, exact pass-through, the upper bounds of the clipped and companded formats, selection of segment 0 below the first knee, and the black-clip forcing of a zero slope. Only the bench's scenarios can show the exact arithmetic: truncation in the divide by 256, the choice of segment exactly at each knee, saturation from negative offsets, and the linear one-eighth setup. The bench compares against a model of the requirements under random configurations and random input codes.

// File: rtl/pwl_pkg.sv
// Shared definitions for the piecewise-linear compander.
// Assumes the output-format field is two bits wide; bit 1 low means companded.
package pwl_pkg;

    typedef enum logic [1:0] {
        FMT_COMP_A = 2'b00,
        FMT_COMP_B = 2'b01,
        FMT_PASS   = 2'b10,
        FMT_CLIP   = 2'b11
    } out_fmt_e;

    // True when the format field selects the companded curve.
    function automatic logic is_companded(input logic [1:0] fmt);
        return fmt[1] == 1'b0;
    endfunction

endpackage

// File: rtl/pwl_seg_select.sv
// Stage 1 of the compander: compares the input with every knee, counts
// how many knees it has reached, and registers that segment's slope and
// offset with the code and format. Black-clip is handled here by choosing
// a zero slope and the first offset. Assumes knees are ordered ascending.
module pwl_seg_select
    import pwl_pkg::*;
#(
    parameter int CODE_W     = 13,
    parameter int NSEG       = 4,
    parameter int SLOPE_W    = 12,
    parameter int OFS_W      = 14,
    parameter int BLACK_CODE = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_vld,
    input  logic [CODE_W-1:0]               in_code,
    input  logic [1:0]                      in_mode,
    input  logic                            in_blk_clip,
    input  logic [NSEG-2:0][CODE_W-1:0]     cfg_knee,
    input  logic [NSEG-1:0][SLOPE_W-1:0]    cfg_slope,
    input  logic [NSEG-1:0][OFS_W-1:0]      cfg_ofs,
    output logic                            s_vld,
    output logic [CODE_W-1:0]               s_code,
    output logic [1:0]                      s_mode,
    output logic [SLOPE_W-1:0]              s_slope,
    output logic [OFS_W-1:0]                s_ofs
);
    localparam int NKNEE = NSEG - 1;
    localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1;
    localparam logic [CODE_W-1:0] BLACK = CODE_W'(BLACK_CODE);

    logic [NKNEE-1:0] at_or_above;
    logic [SEG_W-1:0] seg_idx;
    logic             force_black;

    // One comparator per knee.
    for (genvar k = 0; k < NKNEE; k++) begin : g_knee
        assign at_or_above[k] = (in_code >= cfg_knee[k]);
    end

    // Segment index is the number of knees the input has reached.
    always_comb begin
        seg_idx = '0;
        for (int k = 0; k < NKNEE; k++) begin
            seg_idx = seg_idx + SEG_W'(at_or_above[k]);
        end
    end

    // Black-clip applies only to companded inputs below the black code.
    assign force_black = in_blk_clip && is_companded(in_mode) && (in_code < BLACK);

    // Register the segment constants together with the code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_vld   <= 1'b0;
            s_code  <= '0;
            s_mode  <= 2'b00;
            s_slope <= '0;
            s_ofs   <= '0;
        end else begin
            s_vld   <= in_vld;
            s_code  <= in_code;
            s_mode  <= in_mode;
            s_slope <= force_black ? '0 : cfg_slope[seg_idx];
            s_ofs   <= force_black ? cfg_ofs[0] : cfg_ofs[seg_idx];
        end
    end

    // R4: below the first knee, segment 0 constants are taken.
    assert_first_segment_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !force_black && (in_code < cfg_knee[0]))
        |=> (s_slope == $past(cfg_slope[0])) && (s_ofs == $past(cfg_ofs[0])));

    // R7: a forced black code carries zero slope and the first offset.
    assert_black_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_blk_clip && !in_mode[1] && (in_code < BLACK))
        |=> (s_slope == '0) && (s_ofs == $past(cfg_ofs[0])));

endmodule

// File: rtl/pwl_seg_eval.sv
// Stage 2 of the compander: multiplies the code by the selected slope,
// drops the low scale bits, adds the signed offset and saturates to the
// companded range. Then it picks the output format and registers the result.
module pwl_seg_eval
    import pwl_pkg::*;
#(
    parameter int CODE_W   = 13,
    parameter int SLOPE_W  = 12,
    parameter int OFS_W    = 14,
    parameter int COMP_W   = 10,
    parameter int CLIP_W   = 12,
    parameter int SCALE_SH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_vld,
    input  logic [CODE_W-1:0]    s_code,
    input  logic [1:0]           s_mode,
    input  logic [SLOPE_W-1:0]   s_slope,
    input  logic [OFS_W-1:0]     s_ofs,
    output logic                 out_vld,
    output logic [CODE_W-1:0]    out_code
);
    localparam int PROD_W = CODE_W + SLOPE_W;
    localparam int SUM_W  = PROD_W + 2;
    localparam logic signed [SUM_W-1:0] SAT_HI   = SUM_W'((1 << COMP_W) - 1);
    localparam logic [CODE_W-1:0]       CLIP_MAX = CODE_W'((1 << CLIP_W) - 1);

    logic [PROD_W-1:0]        product;
    logic [PROD_W-1:0]        scaled;
    logic signed [OFS_W-1:0]  ofs_s;
    logic signed [SUM_W-1:0]  sum;
    logic [COMP_W-1:0]        comp_val;
    logic [CODE_W-1:0]        fmt_val;

    // Scaled multiply-add in the signed domain.
    always_comb begin
        product = PROD_W'(s_code) * PROD_W'(s_slope);
        scaled  = product >> SCALE_SH;
        ofs_s   = $signed(s_ofs);
        sum     = SUM_W'($signed({1'b0, scaled})) + SUM_W'(ofs_s);
    end

    // Saturate the sum to the companded range.
    always_comb begin
        if (sum < 0)
            comp_val = '0;
        else if (sum > SAT_HI)
            comp_val = '1;
        else
            comp_val = sum[COMP_W-1:0];
    end

    // Select the output format.
    always_comb begin
        case (s_mode)
            FMT_PASS: fmt_val = s_code;
            FMT_CLIP: fmt_val = (s_code > CLIP_MAX) ? CLIP_MAX : s_code;
            default:  fmt_val = CODE_W'(comp_val);
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_code <= '0;
        end else begin
            out_vld  <= s_vld;
            out_code <= fmt_val;
        end
    end

    // R1/R6: the companded output never leaves the 10-bit range.
    assert_comp_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && !s_mode[1]) |=> (out_code <= CODE_W'((1 << COMP_W) - 1)));

    // R3: the clipped format never exceeds the 12-bit maximum.
    assert_clip_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && (s_mode == 2'b11)) |=> (out_code <= CLIP_MAX));

    // R3: codes inside the 12-bit range pass the clipped format unchanged.
    assert_clip_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && (s_mode == 2'b11) && (s_code <= CLIP_MAX)) |=> (out_code == $past(s_code)));

endmodule

// File: rtl/pwl_compander.sv
// Top of the piecewise-linear compander: a segment-select stage followed
// by an evaluate-and-format stage, with two cycles of latency from input
// to output. Assumes the configuration stays stable while a valid code
// is in stage 1.
module pwl_compander
    import pwl_pkg::*;
#(
    parameter int CODE_W     = 13,
    parameter int NSEG       = 4,
    parameter int SLOPE_W    = 12,
    parameter int OFS_W      = 14,
    parameter int COMP_W     = 10,
    parameter int CLIP_W     = 12,
    parameter int BLACK_CODE = 64,
    parameter int SCALE_SH   = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_vld,
    input  logic [CODE_W-1:0]               in_code,
    input  logic [1:0]                      cfg_mode,
    input  logic                            cfg_blk_clip,
    input  logic [NSEG-2:0][CODE_W-1:0]     cfg_knee,
    input  logic [NSEG-1:0][SLOPE_W-1:0]    cfg_slope,
    input  logic [NSEG-1:0][OFS_W-1:0]      cfg_ofs,
    output logic                            out_vld,
    output logic [CODE_W-1:0]               out_code
);
    logic                s_vld;
    logic [CODE_W-1:0]   s_code;
    logic [1:0]          s_mode;
    logic [SLOPE_W-1:0]  s_slope;
    logic [OFS_W-1:0]    s_ofs;
    logic [1:0]          since_rst;

    pwl_seg_select #(
        .CODE_W(CODE_W), .NSEG(NSEG), .SLOPE_W(SLOPE_W),
        .OFS_W(OFS_W), .BLACK_CODE(BLACK_CODE)
    ) u_select (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_code(in_code), .in_mode(cfg_mode),
        .in_blk_clip(cfg_blk_clip),
        .cfg_knee(cfg_knee), .cfg_slope(cfg_slope), .cfg_ofs(cfg_ofs),
        .s_vld(s_vld), .s_code(s_code), .s_mode(s_mode),
        .s_slope(s_slope), .s_ofs(s_ofs)
    );

    pwl_seg_eval #(
        .CODE_W(CODE_W), .SLOPE_W(SLOPE_W), .OFS_W(OFS_W),
        .COMP_W(COMP_W), .CLIP_W(CLIP_W), .SCALE_SH(SCALE_SH)
    ) u_eval (
        .clk(clk), .rst_n(rst_n),
        .s_vld(s_vld), .s_code(s_code), .s_mode(s_mode),
        .s_slope(s_slope), .s_ofs(s_ofs),
        .out_vld(out_vld), .out_code(out_code)
    );

    // Counts clock edges since reset, up to two, so the checks below
    // never look back into the reset period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= 2'd0;
        else if (since_rst != 2'd2)
            since_rst <= since_rst + 2'd1;
    end

    // R8: valid leaves the block exactly two edges after it enters.
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_vld == $past(in_vld, 2)));

    // R2: the pass-through format returns the input code unchanged.
    assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 2'd2) && out_vld && ($past(cfg_mode, 2) == 2'b10))
        |-> (out_code == $past(in_code, 2)));

endmodule

// File: tb/pwl_compander_bench.sv
// Self-checking bench for pwl_compander: directed corner cases plus
// seeded random streams, compared against a model of the requirements.
module pwl_compander_bench;
    localparam int HALF = 2;          // 4-unit period, 250 MHz nominal
    localparam int LIMIT = 200000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_vld = 1'b0;
    logic [12:0]          in_code = '0;
    logic [1:0]           cfg_mode = 2'b00;
    logic                 cfg_blk_clip = 1'b0;
    logic [2:0][12:0]     cfg_knee = '0;
    logic [3:0][11:0]     cfg_slope = '0;
    logic [3:0][13:0]     cfg_ofs = '0;
    logic                 out_vld;
    logic [12:0]          out_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic  p_vld [2];
    int    p_exp [2];
    int    p_in  [2];
    string p_tag [2];

    always #HALF clk = ~clk;

    pwl_compander u_pwl_compander (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_code(in_code),
        .cfg_mode(cfg_mode), .cfg_blk_clip(cfg_blk_clip),
        .cfg_knee(cfg_knee), .cfg_slope(cfg_slope), .cfg_ofs(cfg_ofs),
        .out_vld(out_vld), .out_code(out_code)
    );

    // Model of R1-R7 using the configuration currently driven.
    function automatic int model(int x, logic [1:0] m, logic c);
        int seg;
        int v;
        if (m == 2'b10) return x;
        if (m == 2'b11) return (x > 4095) ? 4095 : x;
        if (c && x < 64) begin
            v = int'($signed(cfg_ofs[0]));
        end else begin
            seg = 0;
            for (int k = 0; k < 3; k++) if (x >= int'(cfg_knee[k])) seg = k + 1;
            v = int'($signed(cfg_ofs[seg])) + (x * int'(cfg_slope[seg])) / 256;
        end
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        return v;
    endfunction

    task automatic check(input string tag, input int got, input int exp, input int x);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: in=%0d got %0d expected %0d", tag, x, got, exp);
        end
    endtask

    // At a falling edge: check the output due now, then drive the next input.
    task automatic step(input logic v, input int x, input logic [1:0] m,
                        input logic c, input string tag);
        @(negedge clk);
        check("R8", int'(out_vld), int'(p_vld[1]), p_in[1]);
        if (p_vld[1]) check(p_tag[1], int'(out_code), p_exp[1], p_in[1]);
        p_vld[1] = p_vld[0]; p_exp[1] = p_exp[0]; p_in[1] = p_in[0]; p_tag[1] = p_tag[0];
        in_vld = v; in_code = 13'(x); cfg_mode = m; cfg_blk_clip = c;
        p_vld[0] = v; p_exp[0] = model(x, m, c); p_in[0] = x; p_tag[0] = tag;
    endtask

    task automatic bubble(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 2'b00, 1'b0, "R8");
    endtask

    function automatic string pick_tag(int x, logic [1:0] m, logic c);
        if (m == 2'b10) return "R2";
        if (m == 2'b11) return "R3";
        if (c && x < 64) return "R7";
        return "R5";
    endfunction

    task automatic random_cfg();
        int a, b, t;
        int k [3];
        for (int i = 0; i < 3; i++) k[i] = $urandom % 8192;
        for (int i = 0; i < 2; i++)
            for (int j = 0; j < 2 - i; j++)
                if (k[j] > k[j+1]) begin t = k[j]; k[j] = k[j+1]; k[j+1] = t; end
        for (int i = 0; i < 3; i++) cfg_knee[i] = 13'(k[i]);
        for (int i = 0; i < 4; i++) begin
            a = $urandom % 1024;
            b = int'($urandom % 2400) - 1200;
            cfg_slope[i] = 12'(a);
            cfg_ofs[i] = 14'(b);
        end
    endtask

    initial begin
        int x;
        logic [1:0] m;
        logic c;
        void'($urandom(32'h5EED_0C0D));
        for (int i = 0; i < 2; i++) begin p_vld[i] = 1'b0; p_exp[i] = 0; p_in[i] = 0; p_tag[i] = "R8"; end

        // Reset state (R9): drive valid during reset, outputs must stay cleared.
        in_vld = 1'b1; in_code = 13'd4000; cfg_mode = 2'b10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", int'(out_vld), 0, 0);
        check("R9", int'(out_code), 0, 0);
        in_vld = 1'b0;
        rst_n = 1'b1;

        // Linear one-eighth setup (R10) and segment 0 below black (R7).
        cfg_knee = {3{13'd8191}};
        cfg_slope = {4{12'd32}};
        cfg_ofs = '0;
        foreach (p_vld[i]) p_vld[i] = 1'b0;
        step(1'b1, 0,    2'b00, 1'b0, "R10");
        step(1'b1, 7,    2'b01, 1'b0, "R10");
        step(1'b1, 15,   2'b00, 1'b0, "R7");
        step(1'b1, 1234, 2'b00, 1'b0, "R10");
        step(1'b1, 8190, 2'b00, 1'b0, "R10");
        step(1'b1, 8191, 2'b00, 1'b0, "R1");
        bubble(2);

        // Knee boundaries (R4) with distinct segment constants.
        cfg_knee[0] = 13'd1000; cfg_knee[1] = 13'd3000; cfg_knee[2] = 13'd6000;
        cfg_slope[0] = 12'd200; cfg_slope[1] = 12'd100; cfg_slope[2] = 12'd40; cfg_slope[3] = 12'd10;
        cfg_ofs[0] = 14'd8; cfg_ofs[1] = 14'd200; cfg_ofs[2] = 14'd500; cfg_ofs[3] = 14'd700;
        step(1'b1, 999,  2'b00, 1'b0, "R4");
        step(1'b1, 1000, 2'b00, 1'b0, "R4");
        step(1'b1, 2999, 2'b00, 1'b0, "R4");
        step(1'b1, 3000, 2'b00, 1'b0, "R4");
        step(1'b1, 5999, 2'b00, 1'b0, "R4");
        step(1'b1, 6000, 2'b00, 1'b0, "R4");
        step(1'b1, 255,  2'b00, 1'b0, "R5");
        // Black clip (R7) against the same setup.
        step(1'b1, 63,   2'b00, 1'b1, "R7");
        step(1'b1, 0,    2'b00, 1'b1, "R7");
        step(1'b1, 64,   2'b00, 1'b1, "R7");
        step(1'b1, 63,   2'b00, 1'b0, "R7");
        // Other formats (R2, R3).
        step(1'b1, 4095, 2'b11, 1'b0, "R3");
        step(1'b1, 4096, 2'b11, 1'b0, "R3");
        step(1'b1, 8191, 2'b11, 1'b1, "R3");
        step(1'b1, 5000, 2'b10, 1'b1, "R2");
        step(1'b1, 10,   2'b10, 1'b0, "R2");
        bubble(2);

        // Saturation at both ends (R6) and a negative black-clip offset.
        cfg_slope[3] = 12'd4095; cfg_ofs[3] = 14'd900;
        cfg_ofs[0] = 14'(-300);
        step(1'b1, 8000, 2'b00, 1'b0, "R6");
        step(1'b1, 100,  2'b00, 1'b0, "R6");
        step(1'b1, 20,   2'b00, 1'b1, "R6");
        step(1'b0, 8191, 2'b00, 1'b0, "R8");
        step(1'b1, 6001, 2'b00, 1'b0, "R6");
        bubble(2);

        // Random streams under random configurations.
        for (int blk = 0; blk < 60; blk++) begin
            random_cfg();
            for (int i = 0; i < 50; i++) begin
                x = ($urandom % 4 == 0) ? int'($urandom % 128) : int'($urandom % 8192);
                m = 2'($urandom);
                c = 1'($urandom);
                step(1'($urandom % 8 != 0), x, m, c, pick_tag(x, m, c));
            end
            bubble(2);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8: watchdog expired, got running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule